// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block sits on the host side of a byte-wide parallel flash device. It takes one request at a time over a valid/ready command port. A request reads a byte, programs a byte, erases one sector or erases the whole device. For a program or an erase, it produces the unlock write cycles the device expects. Each write cycle is shaped by write enable, and its setup time, low pulse and cycle time are set by parameters counted in system clocks.

After the last write, the block reads the target address again and again. Each read is gated by output enable. It stops when data bit 7 shows the final value, or when a timeout counter runs out. On a timeout it writes the read/reset command (F0h) so the device returns to read mode. It then reports the request as done with the error flag set. A read request is a single timed read cycle that returns the byte.

Top module: `nor_seq_top`

## Requirements
- R1: After reset, reqReady is 1, fCeN, fWeN and fOeN are 1, and fDoutEn and rspValid are 0.
- R2: reqOp encoding: 0 read, 1 program, 2 sector erase, 3 chip erase. A program request emits exactly four write cycles, as (address, data): (5555h, AAh), (2AAAh, 55h), (5555h, A0h), (reqAddr, reqData).
- R3: An erase request emits exactly six write cycles: (5555h, AAh), (2AAAh, 55h), (5555h, 80h), (5555h, AAh), (2AAAh, 55h), then (reqAddr, 30h) for a sector erase or (5555h, 10h) for a chip erase.
- R4: Each fWeN low pulse lasts at least WP_CYC clocks. Successive fWeN falling edges are at least WC_CYC clocks apart, and fWeN stays high at least WPH_CYC clocks between pulses.
- R5: While fWeN is low, fAddr and fDout do not change, fDoutEn is 1, fCeN is 0 and fOeN is 1.
- R6: fOeN falls only after it has been high for at least OEH_CYC clocks. fDoutEn is 0 whenever fOeN is low.
- R7: After the writes, the block polls by reads of the target address. A program completes when bit 7 equals bit 7 of reqData. An erase completes when bit 7 reads 1. The response then has rspError = 0 and never arrives while the device still reports busy.
- R8: If polling has not completed within PROG_TMO_CYC clocks (program) or ERASE_TMO_CYC clocks (erase), the block emits one write of F0h at reqAddr. It then responds with rspError = 1.
- R9: A read request performs one read cycle at reqAddr and emits no write cycle. rspData carries the byte read, with rspError = 0.
- R10: reqReady stays 0 from acceptance until the response. rspValid is a one-clock pulse, exactly one per request. A reqValid raised while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Engine idle, request accepted this clock |
| reqOp | input | 2 | Operation code (R2 encoding) |
| reqAddr | input | AW | Target byte or sector address |
| reqData | input | 8 | Byte to program |
| rspValid | output | 1 | One-clock completion pulse |
| rspError | output | 1 | Polling timed out |
| rspData | output | 8 | Last byte read from the device |
| fAddr | output | AW | Flash address bus |
| fDout | output | 8 | Flash write data |
| fDoutEn | output | 1 | Drive enable for fDout |
| fDin | input | 8 | Flash read data |
| fCeN | output | 1 | Flash chip enable, active low |
| fWeN | output | 1 | Flash write enable, active low |
| fOeN | output | 1 | Flash output enable, active low |

## Verification
On every clock, the assertions watch the bus-level timing rules: write pulse width, write cycle spacing and the high time between pulses. They also watch the address and data held stable during a pulse, bus contention with output enable, the output-enable recovery gap, and the ready/response handshake. Only the bench scenarios can show the command content, because that needs a device model to judge it. These scenarios cover the exact unlock byte sequences for each operation, and completion only after the modelled device leaves its busy state. They also cover the timeout path with its reset write and error flag, and the data returned by reads after program and erase.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;
  typedef enum logic [1:0] {
    OP_READ = 2'd0,
    OP_PROG = 2'd1,
    OP_SECT = 2'd2,
    OP_CHIP = 2'd3
  } op_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // latch request, clear step/error
    logic stepNext;  // advance to next write of the sequence
    logic sample;    // capture fDin
    logic tmoClr;    // restart polling timeout
    logic setErr;    // timeout: flag error, switch to reset write
    logic selRead;   // address bus shows target address
  } strobe_t;
endpackage

// File: rtl/nor_seq_dp.sv
module nor_seq_dp
  import nor_seq_pkg::*;
#(
  parameter int AW = 21,
  parameter int unsigned PROG_TMO_CYC = 75000,
  parameter int unsigned ERASE_TMO_CYC = 32'd3750000000
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       st,
  input  logic [1:0]    reqOp,
  input  logic [AW-1:0] reqAddr,
  input  logic [7:0]    reqData,
  input  logic [7:0]    fDin,
  output logic [AW-1:0] fAddr,
  output logic [7:0]    fDout,
  output logic [7:0]    rspData,
  output logic          rspError,
  output logic          reqIsRead,
  output logic          isRead,
  output logic          lastStep,
  output logic          inRecovery,
  output logic          pollOk,
  output logic          tmoHit
);
  localparam int unsigned TMO_MAX = (ERASE_TMO_CYC > PROG_TMO_CYC) ? ERASE_TMO_CYC : PROG_TMO_CYC;
  localparam int TMO_W = $clog2(TMO_MAX + 1) + 1;
  localparam logic [AW-1:0] ADDR_A = AW'(16'h5555);
  localparam logic [AW-1:0] ADDR_B = AW'(16'h2AAA);

  op_e opQ;
  logic [AW-1:0] addrQ, seqAddr;
  logic [7:0] dataQ, rdQ, seqData;
  logic [2:0] step;
  logic rstMode, errQ;
  logic [TMO_W-1:0] tmoQ, tmoLimit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opQ <= OP_READ; addrQ <= '0; dataQ <= '0; rdQ <= '0;
      step <= '0; rstMode <= 1'b0; errQ <= 1'b0; tmoQ <= '0;
    end else begin
      if (st.load) begin
        opQ <= op_e'(reqOp); addrQ <= reqAddr; dataQ <= reqData;
        step <= '0; rstMode <= 1'b0; errQ <= 1'b0;
      end
      if (st.stepNext) step <= step + 3'd1;
      if (st.setErr) begin
        errQ <= 1'b1; rstMode <= 1'b1; step <= '0;
      end
      if (st.sample) rdQ <= fDin;
      if (st.tmoClr) tmoQ <= '0;
      else if (tmoQ != {TMO_W{1'b1}}) tmoQ <= tmoQ + 1'b1;
    end
  end

  // command byte and address for the current write of the unlock sequence
  always_comb begin
    seqAddr = ADDR_A;
    seqData = 8'hAA;
    if (rstMode) begin
      seqAddr = addrQ; seqData = 8'hF0;
    end else begin
      case (step)
        3'd1, 3'd4: begin seqAddr = ADDR_B; seqData = 8'h55; end
        3'd2: seqData = (opQ == OP_PROG) ? 8'hA0 : 8'h80;
        3'd3: if (opQ == OP_PROG) begin seqAddr = addrQ; seqData = dataQ; end
        3'd5: begin
          seqAddr = (opQ == OP_CHIP) ? ADDR_A : addrQ;
          seqData = (opQ == OP_CHIP) ? 8'h10 : 8'h30;
        end
        default: ;
      endcase
    end
  end

  assign tmoLimit   = (opQ == OP_PROG) ? TMO_W'(PROG_TMO_CYC) : TMO_W'(ERASE_TMO_CYC);
  assign tmoHit     = tmoQ >= tmoLimit;
  assign lastStep   = rstMode || ((opQ == OP_PROG) ? (step == 3'd3) : (step == 3'd5));
  assign inRecovery = rstMode;
  assign pollOk     = rdQ[7] == ((opQ == OP_PROG) ? dataQ[7] : 1'b1);
  assign isRead     = opQ == OP_READ;
  assign reqIsRead  = op_e'(reqOp) == OP_READ;
  assign fAddr      = st.selRead ? addrQ : seqAddr;
  assign fDout      = seqData;
  assign rspData    = rdQ;
  assign rspError   = errQ;
endmodule

// File: rtl/nor_seq_ctrl.sv
module nor_seq_ctrl
  import nor_seq_pkg::*;
#(
  parameter int WP_CYC  = 12,
  parameter int WPH_CYC = 5,
  parameter int WC_CYC  = 23,
  parameter int OEH_CYC = 3,
  parameter int ACC_CYC = 23
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqIsRead,
  input  logic    isRead,
  input  logic    lastStep,
  input  logic    inRecovery,
  input  logic    pollOk,
  input  logic    tmoHit,
  output strobe_t st,
  output logic    reqReady,
  output logic    rspValid,
  output logic    fCeN,
  output logic    fWeN,
  output logic    fOeN,
  output logic    fDoutEn
);
  localparam int GAP_CYC  = WC_CYC - WP_CYC - 1;
  localparam int HIGH_CYC = (GAP_CYC > WPH_CYC) ? GAP_CYC : WPH_CYC;
  localparam int M1 = (WP_CYC > HIGH_CYC) ? WP_CYC : HIGH_CYC;
  localparam int M2 = (OEH_CYC > ACC_CYC) ? OEH_CYC : ACC_CYC;
  localparam int MAXC = (M1 > M2) ? M1 : M2;
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [CW-1:0] WP_L   = CW'(WP_CYC - 1);
  localparam logic [CW-1:0] HIGH_L = CW'(HIGH_CYC - 1);
  localparam logic [CW-1:0] OEH_L  = CW'(OEH_CYC - 1);
  localparam logic [CW-1:0] ACC_L  = CW'(ACC_CYC - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_WSET, S_WLOW, S_WHIGH, S_RGAP, S_RLOW, S_REVAL, S_RESP
  } state_e;

  state_e state, stateNx;
  logic [CW-1:0] cnt, cntNx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE; cnt <= '0;
    end else begin
      state <= stateNx; cnt <= cntNx;
    end
  end

  always_comb begin
    st = '0;
    stateNx = state;
    cntNx = (cnt != '0) ? cnt - 1'b1 : cnt;
    case (state)
      S_IDLE: if (reqValid) begin
        st.load = 1'b1;
        if (reqIsRead) begin stateNx = S_RGAP; cntNx = OEH_L; end
        else stateNx = S_WSET;
      end
      S_WSET: begin stateNx = S_WLOW; cntNx = WP_L; end
      S_WLOW: if (cnt == '0) begin stateNx = S_WHIGH; cntNx = HIGH_L; end
      S_WHIGH: if (cnt == '0) begin
        if (!lastStep) begin st.stepNext = 1'b1; stateNx = S_WSET; end
        else if (inRecovery) stateNx = S_RESP;
        else begin st.tmoClr = 1'b1; stateNx = S_RGAP; cntNx = OEH_L; end
      end
      S_RGAP: begin
        st.selRead = 1'b1;
        if (cnt == '0) begin stateNx = S_RLOW; cntNx = ACC_L; end
      end
      S_RLOW: begin
        st.selRead = 1'b1;
        if (cnt == '0) begin st.sample = 1'b1; stateNx = S_REVAL; end
      end
      S_REVAL: begin
        st.selRead = 1'b1;
        if (isRead || pollOk) stateNx = S_RESP;
        else if (tmoHit) begin st.setErr = 1'b1; stateNx = S_WSET; end
        else begin stateNx = S_RGAP; cntNx = OEH_L; end
      end
      S_RESP: stateNx = S_IDLE;
      default: stateNx = S_IDLE;
    endcase
  end

  assign reqReady = state == S_IDLE;
  assign rspValid = state == S_RESP;
  assign fCeN     = (state == S_IDLE) || (state == S_RESP);
  assign fWeN     = state != S_WLOW;
  assign fOeN     = state != S_RLOW;
  assign fDoutEn  = (state == S_WSET) || (state == S_WLOW) || (state == S_WHIGH);
endmodule

// File: rtl/nor_seq_top.sv
module nor_seq_top
  import nor_seq_pkg::*;
#(
  parameter int AW = 21,
  parameter int WP_CYC  = 12,
  parameter int WPH_CYC = 5,
  parameter int WC_CYC  = 23,
  parameter int OEH_CYC = 3,
  parameter int ACC_CYC = 23,
  parameter int unsigned PROG_TMO_CYC = 75000,
  parameter int unsigned ERASE_TMO_CYC = 32'd3750000000
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  output logic          reqReady,
  input  logic [1:0]    reqOp,
  input  logic [AW-1:0] reqAddr,
  input  logic [7:0]    reqData,
  output logic          rspValid,
  output logic          rspError,
  output logic [7:0]    rspData,
  output logic [AW-1:0] fAddr,
  output logic [7:0]    fDout,
  output logic          fDoutEn,
  input  logic [7:0]    fDin,
  output logic          fCeN,
  output logic          fWeN,
  output logic          fOeN
);
  strobe_t st;
  logic reqIsRead, isRead, lastStep, inRecovery, pollOk, tmoHit;

  nor_seq_ctrl #(
    .WP_CYC(WP_CYC), .WPH_CYC(WPH_CYC), .WC_CYC(WC_CYC),
    .OEH_CYC(OEH_CYC), .ACC_CYC(ACC_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqIsRead(reqIsRead),
    .isRead(isRead), .lastStep(lastStep), .inRecovery(inRecovery),
    .pollOk(pollOk), .tmoHit(tmoHit), .st(st), .reqReady(reqReady),
    .rspValid(rspValid), .fCeN(fCeN), .fWeN(fWeN), .fOeN(fOeN), .fDoutEn(fDoutEn)
  );

  nor_seq_dp #(
    .AW(AW), .PROG_TMO_CYC(PROG_TMO_CYC), .ERASE_TMO_CYC(ERASE_TMO_CYC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .reqOp(reqOp), .reqAddr(reqAddr),
    .reqData(reqData), .fDin(fDin), .fAddr(fAddr), .fDout(fDout),
    .rspData(rspData), .rspError(rspError), .reqIsRead(reqIsRead),
    .isRead(isRead), .lastStep(lastStep), .inRecovery(inRecovery),
    .pollOk(pollOk), .tmoHit(tmoHit)
  );
endmodule

// File: rtl/nor_seq_chk.sv
module nor_seq_chk #(
  parameter int AW = 21,
  parameter int WP_CYC  = 12,
  parameter int WPH_CYC = 5,
  parameter int WC_CYC  = 23,
  parameter int OEH_CYC = 3
) (
  input logic          clk,
  input logic          rstN,
  input logic          reqValid,
  input logic          reqReady,
  input logic          rspValid,
  input logic [AW-1:0] fAddr,
  input logic [7:0]    fDout,
  input logic          fDoutEn,
  input logic          fCeN,
  input logic          fWeN,
  input logic          fOeN
);
  localparam logic [15:0] SAT = 16'hFFFF;
  logic [15:0] lowCnt, highCnt, sinceFall, oeHigh;
  logic prevWe;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowCnt <= '0; highCnt <= SAT; sinceFall <= SAT; oeHigh <= SAT; prevWe <= 1'b1;
    end else begin
      prevWe <= fWeN;
      lowCnt <= fWeN ? 16'd0 : ((lowCnt == SAT) ? SAT : lowCnt + 16'd1);
      highCnt <= !fWeN ? 16'd0 : ((highCnt == SAT) ? SAT : highCnt + 16'd1);
      if (!fWeN && prevWe) sinceFall <= 16'd1;
      else if (sinceFall != SAT) sinceFall <= sinceFall + 16'd1;
      oeHigh <= !fOeN ? 16'd0 : ((oeHigh == SAT) ? SAT : oeHigh + 16'd1);
    end
  end

  p_we_width_r4: assert property (@(posedge clk) disable iff (!rstN)
    (fWeN && !prevWe) |-> lowCnt >= 16'(WP_CYC));
  p_we_high_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!fWeN && prevWe) |-> highCnt >= 16'(WPH_CYC));
  p_we_cycle_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!fWeN && prevWe) |-> sinceFall >= 16'(WC_CYC));
  p_bus_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!fWeN && !prevWe) |-> ($stable(fAddr) && $stable(fDout)));
  p_write_ctl_r5: assert property (@(posedge clk) disable iff (!rstN)
    !fWeN |-> (fOeN && fDoutEn && !fCeN));
  p_oe_gap_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(fOeN) |-> oeHigh >= 16'(OEH_CYC));
  p_no_contention_r6: assert property (@(posedge clk) disable iff (!rstN)
    !fOeN |-> !fDoutEn);
  p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);
  p_rsp_not_ready_r10: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !reqReady);
  p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);
endmodule

bind nor_seq_top nor_seq_chk #(
  .AW(AW), .WP_CYC(WP_CYC), .WPH_CYC(WPH_CYC), .WC_CYC(WC_CYC), .OEH_CYC(OEH_CYC)
) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .rspValid(rspValid), .fAddr(fAddr), .fDout(fDout), .fDoutEn(fDoutEn),
  .fCeN(fCeN), .fWeN(fWeN), .fOeN(fOeN)
);

// File: tb/nor_seq_top_test.sv
`timescale 1ns/1ps
module nor_seq_top_test;
  localparam int AW = 21;
  localparam int PROG_TMO = 400;
  localparam int ERASE_TMO = 3000;
  localparam int PROG_BUSY = 150;
  localparam int ERASE_BUSY = 700;
  // minima from the 4 ns clock: 45 ns, 20 ns, 90 ns, 10 ns
  localparam int MIN_WP = 12, MIN_WPH = 5, MIN_WC = 23, MIN_OEH = 3;

  typedef struct packed {
    logic [1:0]    op;
    logic [AW-1:0] a;
    logic [7:0]    d;
    logic [7:0]    rd;
    logic [3:0]    nw;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{2'd1, 21'h000012, 8'h3C, 8'h00, 4'd4},
    '{2'd0, 21'h000012, 8'h00, 8'h3C, 4'd0},
    '{2'd1, 21'h0000A5, 8'hC3, 8'h00, 4'd4},
    '{2'd0, 21'h0000A5, 8'h00, 8'hC3, 4'd0},
    '{2'd2, 21'h1F0000, 8'h00, 8'h00, 4'd6},
    '{2'd0, 21'h000012, 8'h00, 8'hFF, 4'd0},
    '{2'd3, 21'h000000, 8'h00, 8'h00, 4'd6},
    '{2'd0, 21'h0000A5, 8'h00, 8'hFF, 4'd0}
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqReady;
  logic [1:0] reqOp = 2'd0;
  logic [AW-1:0] reqAddr = '0;
  logic [7:0] reqData = '0;
  logic rspValid, rspError;
  logic [7:0] rspData;
  logic [AW-1:0] fAddr;
  logic [7:0] fDout, fDin;
  logic fDoutEn, fCeN, fWeN, fOeN;

  always #2 clk = ~clk;

  nor_seq_top #(.AW(AW), .PROG_TMO_CYC(PROG_TMO), .ERASE_TMO_CYC(ERASE_TMO)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqAddr(reqAddr), .reqData(reqData), .rspValid(rspValid),
    .rspError(rspError), .rspData(rspData), .fAddr(fAddr), .fDout(fDout),
    .fDoutEn(fDoutEn), .fDin(fDin), .fCeN(fCeN), .fWeN(fWeN), .fOeN(fOeN)
  );

  int checks = 0, failures = 0;

  // ---------------- device model ----------------
  logic [7:0] mem [256];
  int busyCnt = 0;
  logic busyBit7 = 1'b0;
  logic stuck = 1'b0;
  int unl = 0;
  logic [AW-1:0] logA [128];
  logic [7:0] logD [128];
  int logN = 0;
  int rspCnt = 0;
  logic prevWe = 1'b1, prevOe = 1'b1;
  int lowRun = 0, fallGap = 0, oeRun = 1000, highRun = 1000;
  int minLow = 1000, minCyc = 1000, minHigh = 1000, minOeGap = 1000;
  logic haveFall = 1'b0;
  int stabErr = 0, contErr = 0;
  logic [AW-1:0] lastA = '0;
  logic [7:0] lastD = '0;

  initial for (int i = 0; i < 256; i++) mem[i] = 8'hFF;

  assign fDin = (!fOeN && !fCeN) ? ((busyCnt != 0) ? {busyBit7, 7'h00} : mem[fAddr[7:0]]) : 8'h00;

  always @(posedge clk) begin
    if (rspValid) rspCnt <= rspCnt + 1;
    if (busyCnt != 0 && !stuck) busyCnt <= busyCnt - 1;
    if (rstN) begin
      // timing monitor
      if (!fWeN) lowRun = lowRun + 1;
      else if (lowRun > 0) begin
        if (lowRun < minLow) minLow = lowRun;
        lowRun = 0;
      end
      if (!fWeN && prevWe) begin
        if (haveFall && fallGap < minCyc) minCyc = fallGap;
        if (haveFall && highRun < minHigh) minHigh = highRun;
        haveFall = 1'b1; fallGap = 0;
      end
      fallGap = fallGap + 1;
      highRun = fWeN ? highRun + 1 : 0;
      if (!fOeN && prevOe && oeRun < minOeGap) minOeGap = oeRun;
      oeRun = fOeN ? oeRun + 1 : 0;
      if (!fWeN && !prevWe && (fAddr != lastA || fDout != lastD)) stabErr++;
      if (!fOeN && fDoutEn) contErr++;
      // write completes on the rising edge of write enable
      if (fWeN && !prevWe && !fCeN) begin
        if (logN < 128) begin logA[logN] = fAddr; logD[logN] = fDout; end
        logN++;
        if (fDout == 8'hF0) begin unl = 0; busyCnt <= 0; end
        else case (unl)
          0: unl = (fAddr == 21'h5555 && fDout == 8'hAA) ? 1 : 0;
          1: unl = (fAddr == 21'h2AAA && fDout == 8'h55) ? 2 : 0;
          2: unl = (fAddr == 21'h5555 && fDout == 8'hA0) ? 3 :
                   (fAddr == 21'h5555 && fDout == 8'h80) ? 4 : 0;
          3: begin
            mem[fAddr[7:0]] <= fDout; busyBit7 <= ~fDout[7];
            busyCnt <= PROG_BUSY; unl = 0;
          end
          4: unl = (fAddr == 21'h5555 && fDout == 8'hAA) ? 5 : 0;
          5: unl = (fAddr == 21'h2AAA && fDout == 8'h55) ? 6 : 0;
          6: begin
            if (fDout == 8'h30 || (fDout == 8'h10 && fAddr == 21'h5555)) begin
              for (int i = 0; i < 256; i++) mem[i] <= 8'hFF;
              busyBit7 <= 1'b0; busyCnt <= ERASE_BUSY;
            end
            unl = 0;
          end
          default: unl = 0;
        endcase
      end
    end
    prevWe = fWeN; prevOe = fOeN; lastA = fAddr; lastD = fDout;
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic void expW(input logic [1:0] op, input int i, input logic [AW-1:0] a,
                               input logic [7:0] d, output logic [AW-1:0] ea, output logic [7:0] ed);
    ea = 21'h5555; ed = 8'hAA;
    case (i)
      1, 4: begin ea = 21'h2AAA; ed = 8'h55; end
      2: ed = (op == 2'd1) ? 8'hA0 : 8'h80;
      3: if (op == 2'd1) begin ea = a; ed = d; end
      5: begin ea = (op == 2'd3) ? 21'h5555 : a; ed = (op == 2'd3) ? 8'h10 : 8'h30; end
      default: ;
    endcase
  endfunction

  int readyHigh = 0;

  task automatic doReq(input logic [1:0] op, input logic [AW-1:0] a, input logic [7:0] d,
                       input bit poke, output logic e, output logic [7:0] rd,
                       output int cyc, output int nw, output int base, output int nrsp);
    int r0;
    @(negedge clk);
    base = logN; r0 = rspCnt;
    reqOp = op; reqAddr = a; reqData = d; reqValid = 1'b1;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0; cyc = 0;
    while (!rspValid && cyc < 60000) begin
      if (reqReady) readyHigh++;
      if (poke && cyc < 30) begin reqValid = 1'b1; reqOp = 2'd3; end
      else reqValid = 1'b0;
      @(negedge clk); cyc++;
    end
    reqValid = 1'b0;
    e = rspError; rd = rspData;
    @(negedge clk);
    nw = logN - base; nrsp = rspCnt - r0;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  // ---------------- main ----------------
  initial begin
    logic e;
    logic [7:0] rd;
    logic [AW-1:0] ea;
    logic [7:0] ed;
    int cyc, nw, base, nrsp, bad;

    repeat (4) @(negedge clk);
    // R1 reset state
    chk(reqReady == 1'b1, "R1", "reqReady", reqReady, 1);
    chk({fCeN, fWeN, fOeN} == 3'b111, "R1", "ce/we/oe", {fCeN, fWeN, fOeN}, 3'b111);
    chk(fDoutEn == 1'b0 && rspValid == 1'b0, "R1", "doutEn/rspValid", {fDoutEn, rspValid}, 0);
    rstN = 1'b1;

    // vector table
    for (int v = 0; v < 8; v++) begin
      doReq(VEC[v].op, VEC[v].a, VEC[v].d, 1'b0, e, rd, cyc, nw, base, nrsp);
      chk(nw == int'(VEC[v].nw), (VEC[v].op == 2'd1) ? "R2" : (VEC[v].op == 2'd0) ? "R9" : "R3",
          "write count", nw, VEC[v].nw);
      bad = 0;
      for (int j = 0; j < int'(VEC[v].nw) && j < nw; j++) begin
        expW(VEC[v].op, j, VEC[v].a, VEC[v].d, ea, ed);
        if (logA[base + j] != ea || logD[base + j] != ed) bad++;
      end
      chk(bad == 0, (VEC[v].op == 2'd1) ? "R2" : "R3", "sequence mismatches", bad, 0);
      chk(e == 1'b0, "R7", "rspError", e, 0);
      chk(nrsp == 1, "R10", "response pulses", nrsp, 1);
      if (VEC[v].op == 2'd0) chk(rd == VEC[v].rd, "R9", "read data", rd, VEC[v].rd);
      else chk(busyCnt == 0, "R7", "device busy at response", busyCnt, 0);
    end

    // R10 busy request ignored
    doReq(2'd1, 21'h000033, 8'h5A, 1'b1, e, rd, cyc, nw, base, nrsp);
    chk(nw == 4, "R10", "writes with poke while busy", nw, 4);
    chk(nrsp == 1, "R10", "responses with poke", nrsp, 1);
    chk(readyHigh == 0, "R10", "ready high while busy", readyHigh, 0);
    doReq(2'd0, 21'h000033, 8'h00, 1'b0, e, rd, cyc, nw, base, nrsp);
    chk(rd == 8'h5A && nw == 0, "R9", "read after program", rd, 8'h5A);

    // R8 timeout
    stuck = 1'b1;
    doReq(2'd1, 21'h000044, 8'h11, 1'b0, e, rd, cyc, nw, base, nrsp);
    stuck = 1'b0;
    chk(e == 1'b1, "R8", "rspError on timeout", e, 1);
    chk(nw == 5, "R8", "write count with reset", nw, 5);
    chk(nw >= 5 && logD[base + 4] == 8'hF0 && logA[base + 4] == 21'h000044,
        "R8", "reset write data", logD[base + 4], 8'hF0);
    chk(cyc > PROG_TMO, "R8", "cycles before timeout", cyc, PROG_TMO);
    chk(busyCnt == 0, "R8", "device back in read mode", busyCnt, 0);
    doReq(2'd0, 21'h000012, 8'h00, 1'b0, e, rd, cyc, nw, base, nrsp);
    chk(e == 1'b0, "R9", "error cleared by next request", e, 0);

    // bus timing summary
    chk(minLow >= MIN_WP, "R4", "min WE low", minLow, MIN_WP);
    chk(minCyc >= MIN_WC, "R4", "min WE cycle", minCyc, MIN_WC);
    chk(minHigh >= MIN_WPH, "R4", "min WE high", minHigh, MIN_WPH);
    chk(stabErr == 0, "R5", "bus change during WE low", stabErr, 0);
    chk(minOeGap >= MIN_OEH, "R6", "min OE high before read", minOeGap, MIN_OEH);
    chk(contErr == 0, "R6", "drive while OE low", contErr, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule